// File: doc/BRIEF.md
# Pseudo-Random Sequence Lane Checker

This block checks the parallel words of one serial receive lane against a pseudo-random bit sequence built on the polynomial x^31 + x^28 + 1. The word width is 16 or 20 bits and a two-bit configuration field selects it. The checker needs no seed from software. It loads its 31-bit history from the first words it receives, then runs free and predicts every following bit itself. Each mismatching bit adds one to an error counter. Each checked word adds one to a sample counter. Both counters are 16 bits wide and stop at their maximum value. A lock flag drops after a run of words that all contain errors, and the checker then loads its history again.

While checking is enabled, the user data output is forced to zero. While checking is disabled, the output carries the incoming word unchanged. A configuration bit reverses the bit order of the word before it is checked. A second configuration bit makes a read of the error counter clear that counter. Software reads both counters through a small read port.

Top module: `prbs_lane_checker`

## Requirements
- R1: After reset the error counter and the sample counter read 0 and `locked` is 0.
- R2: `cfg_width` code 2'b10 selects 16-bit words and uses `rx_word[15:0]`. Code 2'b11 selects 20-bit words. Any other code keeps the checker idle: it counts nothing and `locked` stays 0.
- R3: Bit 0 of a word is the earliest bit on the line. After checking is enabled, and again after lock is lost, the first two valid words load the checker history. They are not counted, and `locked` is 1 after the second of them.
- R4: While locked, every valid word adds exactly one to the sample counter.
- R5: While locked, every valid word adds to the error counter the number of its bits that differ from the sequence x^31 + x^28 + 1. A wrong bit does not disturb the prediction of later bits, so one flipped bit gives one error.
- R6: Both counters stop at 16'hFFFF and never wrap.
- R7: `rd_data` shows the error counter when `rd_sel` is 0 and the sample counter when `rd_sel` is 1, in the same cycle.
- R8: With `cfg_clr_on_read` set, a cycle with `rd_en` = 1 and `rd_sel` = 0 leaves the error counter equal to the errors of a word checked in that same cycle, or 0 if no word is checked.
- R9: With `cfg_clr_on_read` clear, a read does not change the error counter.
- R10: `user_data` equals `rx_word` while `check_en` is 0 and is all zeros while `check_en` is 1.
- R11: With `cfg_bit_rev` set, the active bits of the word are reversed before checking, so bit W-1 is the earliest bit.
- R12: Eight valid locked words in a row, each with at least one error, drop `locked` to 0 and start a new load. An error-free word restarts this run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| check_en | input | 1 | Enables check mode; while 0 the checker is idle and unlocked |
| cfg_width | input | 2 | Word width code (2'b10: 16 bits, 2'b11: 20 bits) |
| cfg_bit_rev | input | 1 | Reverses the bit order of the active word bits |
| cfg_clr_on_read | input | 1 | A read of the error counter clears it |
| rx_word | input | 20 | Parallel receive word, bit 0 earliest |
| rx_valid | input | 1 | Qualifies `rx_word` |
| user_data | output | 20 | Receive data toward the user, zero in check mode |
| rd_en | input | 1 | Read strobe, used for clear-on-read |
| rd_sel | input | 1 | 0: error counter, 1: sample counter |
| rd_data | output | 16 | Selected counter value |
| locked | output | 1 | Checker is synchronized to the sequence |

## Verification
The checker is fed a clean sequence in both widths and in both bit orders. Any count is then a fault in the prediction, in the tap positions or in the reversal. Words with single flipped bits and words with a few flipped bits show whether the per-bit count is exact and whether a wrong bit corrupts the history. Runs of seven and of eight bad words, split by one clean word, locate the lock-loss threshold and the restart of the run count. A fully inverted stream drives the error counter into saturation, and a long clean stream does the same for the sample counter. A clear-on-read in the same cycle as an errored word shows that the two updates are merged correctly.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
   // polynomial x^ORDER + x^TAP + 1
   localparam int PRBS_ORDER = 31;
   localparam int PRBS_TAP   = 28;
   // word width select codes
   localparam logic [1:0] WSEL_NARROW = 2'b10;
   localparam logic [1:0] WSEL_WIDE   = 2'b11;
   // read select codes
   localparam logic RSEL_ERR = 1'b0;
   localparam logic RSEL_SMP = 1'b1;
endpackage

// File: rtl/prbs_bit_order.sv
module prbs_bit_order #(
   parameter int NARROW_W = 16,
   parameter int WIDE_W   = 20
) (
   input  logic [WIDE_W-1:0] word_i,
   input  logic              wide_i,
   input  logic              rev_i,
   output logic [WIDE_W-1:0] word_o
);
   logic [WIDE_W-1:0] rev_wide;
   logic [WIDE_W-1:0] rev_narrow;

   for (genvar i = 0; i < WIDE_W; i++) begin : g_rev
      assign rev_wide[i] = word_i[WIDE_W-1-i];
      if (i < NARROW_W) begin : g_low
         assign rev_narrow[i] = word_i[NARROW_W-1-i];
      end else begin : g_high
         assign rev_narrow[i] = 1'b0;
      end
   end

   always_comb begin
      if (!rev_i)      word_o = word_i;
      else if (wide_i) word_o = rev_wide;
      else             word_o = rev_narrow;
   end
endmodule

// File: rtl/prbs_word_predict.sv
module prbs_word_predict
   import prbs_chk_pkg::*;
#(
   parameter int NARROW_W = 16,
   parameter int WIDE_W   = 20,
   localparam int CNT_W   = $clog2(WIDE_W + 1)
) (
   input  logic [PRBS_ORDER-1:0] hist_i,
   input  logic [WIDE_W-1:0]     data_i,
   input  logic                  wide_i,
   input  logic                  seeding_i,
   output logic [PRBS_ORDER-1:0] hist_o,
   output logic [CNT_W-1:0]      nerr_o
);
   logic [PRBS_ORDER-1:0] h;
   logic [CNT_W-1:0]      cnt;
   logic                  pbit;

   // hist[k] holds the bit received k+1 positions ago
   always_comb begin
      h    = hist_i;
      cnt  = '0;
      pbit = 1'b0;
      for (int i = 0; i < WIDE_W; i++) begin
         if (i < NARROW_W || wide_i) begin
            pbit = h[PRBS_ORDER-1] ^ h[PRBS_TAP-1];
            if (!seeding_i && (pbit != data_i[i])) cnt = cnt + 1'b1;
            h = {h[PRBS_ORDER-2:0], seeding_i ? data_i[i] : pbit};
         end
      end
      hist_o = h;
      nerr_o = cnt;
   end
endmodule

// File: rtl/prbs_sat_counter.sv
module prbs_sat_counter #(
   parameter int CNT_W = 16,
   parameter int INC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [INC_W-1:0] inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W:0] sum;

   always_comb sum = {1'b0, (clr_i ? '0 : cnt_o)} + (CNT_W+1)'(inc_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (sum[CNT_W]) cnt_o <= '1;
      else             cnt_o <= sum[CNT_W-1:0];
   end
endmodule

// File: rtl/prbs_lane_checker.sv
module prbs_lane_checker
   import prbs_chk_pkg::*;
#(
   parameter int NARROW_W   = 16,
   parameter int WIDE_W     = 20,
   parameter int CNT_W      = 16,
   parameter int LOSS_LIMIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              check_en,
   input  logic [1:0]        cfg_width,
   input  logic              cfg_bit_rev,
   input  logic              cfg_clr_on_read,
   input  logic [WIDE_W-1:0] rx_word,
   input  logic              rx_valid,
   output logic [WIDE_W-1:0] user_data,
   input  logic              rd_en,
   input  logic              rd_sel,
   output logic [CNT_W-1:0]  rd_data,
   output logic              locked
);
   localparam int NERR_W     = $clog2(WIDE_W + 1);
   localparam int SEED_WORDS = (PRBS_ORDER + NARROW_W - 1) / NARROW_W;
   localparam int SEED_CW    = $clog2(SEED_WORDS + 1);
   localparam int RUN_CW     = $clog2(LOSS_LIMIT + 1);

   if (WIDE_W < NARROW_W) begin : g_bad_width
      $error("WIDE_W must not be below NARROW_W");
   end
   if (LOSS_LIMIT < 1) begin : g_bad_limit
      $error("LOSS_LIMIT must be at least 1");
   end
   if (CNT_W < NERR_W) begin : g_bad_cnt
      $error("CNT_W too small for one word of errors");
   end

   logic                  wide, active, take;
   logic [WIDE_W-1:0]     ordered;
   logic [PRBS_ORDER-1:0] hist_q, hist_nx;
   logic [NERR_W-1:0]     nerr;
   logic                  lock_q;
   logic [SEED_CW-1:0]    seed_cnt;
   logic [RUN_CW-1:0]     bad_run;
   logic [CNT_W-1:0]      err_cnt, smp_cnt;
   logic                  err_clr;

   assign wide   = (cfg_width == WSEL_WIDE);
   assign active = check_en && (cfg_width == WSEL_NARROW || cfg_width == WSEL_WIDE);
   assign take   = active && rx_valid && lock_q;

   prbs_bit_order #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_order (
      .word_i(rx_word), .wide_i(wide), .rev_i(cfg_bit_rev), .word_o(ordered)
   );

   prbs_word_predict #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_pred (
      .hist_i(hist_q), .data_i(ordered), .wide_i(wide), .seeding_i(!lock_q),
      .hist_o(hist_nx), .nerr_o(nerr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q   <= '0;
         lock_q   <= 1'b0;
         seed_cnt <= '0;
         bad_run  <= '0;
      end else if (!active) begin
         lock_q   <= 1'b0;
         seed_cnt <= '0;
         bad_run  <= '0;
      end else if (rx_valid) begin
         hist_q <= hist_nx;
         if (!lock_q) begin
            if (seed_cnt == SEED_CW'(SEED_WORDS - 1)) begin
               lock_q   <= 1'b1;
               seed_cnt <= '0;
               bad_run  <= '0;
            end else begin
               seed_cnt <= seed_cnt + 1'b1;
            end
         end else if (nerr != '0) begin
            if (bad_run == RUN_CW'(LOSS_LIMIT - 1)) begin
               lock_q  <= 1'b0;
               bad_run <= '0;
            end else begin
               bad_run <= bad_run + 1'b1;
            end
         end else begin
            bad_run <= '0;
         end
      end
   end

   assign err_clr = rd_en && (rd_sel == RSEL_ERR) && cfg_clr_on_read;

   prbs_sat_counter #(.CNT_W(CNT_W), .INC_W(NERR_W)) u_err_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(err_clr),
      .inc_i(take ? nerr : '0), .cnt_o(err_cnt)
   );

   prbs_sat_counter #(.CNT_W(CNT_W), .INC_W(1)) u_smp_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(1'b0),
      .inc_i(take), .cnt_o(smp_cnt)
   );

   assign rd_data   = (rd_sel == RSEL_SMP) ? smp_cnt : err_cnt;
   assign user_data = check_en ? '0 : rx_word;
   assign locked    = lock_q;
endmodule

// File: rtl/prbs_lane_checker_sva.sv
module prbs_lane_checker_sva #(
   parameter int WIDE_W = 20,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              check_en,
   input logic              cfg_clr_on_read,
   input logic              rd_en,
   input logic              rd_sel,
   input logic [WIDE_W-1:0] user_data,
   input logic              lock_q,
   input logic [CNT_W-1:0]  err_cnt,
   input logic [CNT_W-1:0]  smp_cnt
);
   assert_user_muted_R10: assert property (@(posedge clk) disable iff (!rst_n)
      check_en |-> (user_data == '0));

   assert_sample_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (smp_cnt == $past(smp_cnt)) || (smp_cnt == $past(smp_cnt) + 1'b1));

   assert_sample_hold_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_cnt == '1) |=> (smp_cnt == '1));

   assert_err_hold_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt == '1) && !(rd_en && !rd_sel && cfg_clr_on_read) |=> (err_cnt == '1));

   assert_err_no_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && !rd_sel && cfg_clr_on_read) |=> (err_cnt >= $past(err_cnt)));

   assert_unlocked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_q |=> $stable(smp_cnt) && $stable(err_cnt));
endmodule

bind prbs_lane_checker prbs_lane_checker_sva #(.WIDE_W(WIDE_W), .CNT_W(CNT_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .check_en(check_en), .cfg_clr_on_read(cfg_clr_on_read),
   .rd_en(rd_en), .rd_sel(rd_sel), .user_data(user_data), .lock_q(lock_q),
   .err_cnt(err_cnt), .smp_cnt(smp_cnt)
);

// File: tb/prbs_lane_checker_tb_top.sv
module prbs_lane_checker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        check_en = 1'b0;
   logic [1:0]  cfg_width = 2'b10;
   logic        cfg_bit_rev = 1'b0;
   logic        cfg_clr_on_read = 1'b0;
   logic [19:0] rx_word = '0;
   logic        rx_valid = 1'b0;
   logic [19:0] user_data;
   logic        rd_en = 1'b0;
   logic        rd_sel = 1'b0;
   logic [15:0] rd_data;
   logic        locked;

   int checks = 0;
   int fails  = 0;
   logic [30:0] gs = 31'h1234567;   // reference sequence state

   always #5 clk = ~clk;

   prbs_lane_checker dut_i (
      .clk(clk), .rst_n(rst_n), .check_en(check_en), .cfg_width(cfg_width),
      .cfg_bit_rev(cfg_bit_rev), .cfg_clr_on_read(cfg_clr_on_read),
      .rx_word(rx_word), .rx_valid(rx_valid), .user_data(user_data),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .locked(locked)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // next word of the reference sequence, bit 0 earliest unless reversed
   task automatic gen(input int w, input logic rev, output logic [19:0] word);
      logic [19:0] t = '0;
      for (int i = 0; i < w; i++) begin
         logic b = gs[30] ^ gs[27];
         gs   = {gs[29:0], b};
         t[i] = b;
      end
      word = '0;
      for (int i = 0; i < w; i++) word[i] = rev ? t[w-1-i] : t[i];
   endtask

   task automatic send(input logic [19:0] word);
      @(negedge clk);
      rx_word  = word;
      rx_valid = 1'b1;
      @(posedge clk);
      #1 rx_valid = 1'b0;
   endtask

   task automatic send_seq(input int n, input int w, input logic [19:0] flip);
      for (int k = 0; k < n; k++) begin
         logic [19:0] wd;
         gen(w, cfg_bit_rev, wd);
         send(wd ^ flip);
      end
   endtask

   task automatic rd(input logic sel, output logic [15:0] v);
      @(negedge clk);
      rd_sel = sel;
      #1 v = rd_data;
   endtask

   task automatic restart;
      @(negedge clk) check_en = 1'b0;
      @(negedge clk) check_en = 1'b1;
   endtask

   task automatic t_reset;
      logic [15:0] v;
      rd(1'b0, v); chk("R1 err after reset", v, 0);
      rd(1'b1, v); chk("R1 smp after reset", v, 0);
      chk("R1 locked after reset", locked, 0);
   endtask

   task automatic t_user_data;
      @(negedge clk);
      check_en = 1'b0; rx_word = 20'hA5C3F;
      #1 chk("R10 pass-through", user_data, 20'hA5C3F);
      check_en = 1'b1;
      #1 chk("R10 muted in check mode", user_data, 0);
      check_en = 1'b0;
   endtask

   task automatic t_clean16;
      logic [15:0] v;
      restart();
      cfg_width = 2'b10;
      send_seq(1, 16, 0);
      chk("R3 not locked after one seed word", locked, 0);
      send_seq(1, 16, 0);
      chk("R3 locked after two seed words", locked, 1);
      rd(1'b1, v); chk("R3 seed words not counted", v, 0);
      send_seq(10, 16, 0);
      rd(1'b1, v); chk("R4 ten samples", v, 10);
      rd(1'b0, v); chk("R5 clean 16-bit stream no errors", v, 0);
   endtask

   task automatic t_inject;
      logic [15:0] v;
      send_seq(1, 16, 20'h00109);   // three flipped bits
      send_seq(3, 16, 0);
      rd(1'b0, v); chk("R5 three flipped bits counted once", v, 3);
      rd(1'b1, v); chk("R2 upper bits ignored in 16-bit mode", v, 14);
      send_seq(1, 16, 20'hF0000);   // flips outside the 16-bit word
      rd(1'b0, v); chk("R2 bits above 16 not checked", v, 3);
   endtask

   task automatic t_read_clear;
      logic [15:0] v;
      cfg_clr_on_read = 1'b0;
      @(negedge clk) rd_en = 1'b1; rd_sel = 1'b0;
      @(posedge clk) #1 rd_en = 1'b0;
      rd(1'b0, v); chk("R9 read without clear keeps count", v, 3);
      cfg_clr_on_read = 1'b1;
      @(negedge clk) rd_en = 1'b1; rd_sel = 1'b0;
      #1 chk("R7 read shows error count", rd_data, 3);
      @(posedge clk) #1 rd_en = 1'b0;
      rd(1'b0, v); chk("R8 cleared by read", v, 0);
      // clear and new errors in the same cycle
      send_seq(1, 16, 20'h00001);
      begin
         logic [19:0] wd;
         gen(16, 1'b0, wd);
         @(negedge clk);
         rx_word = wd ^ 20'h08800; rx_valid = 1'b1; rd_en = 1'b1; rd_sel = 1'b0;
         @(posedge clk) #1 rx_valid = 1'b0; rd_en = 1'b0;
      end
      rd(1'b0, v); chk("R8 clear merged with same-cycle errors", v, 2);
      @(negedge clk) rd_en = 1'b1; rd_sel = 1'b0;
      @(posedge clk) #1 rd_en = 1'b0;
      cfg_clr_on_read = 1'b0;
   endtask

   task automatic t_wide_rev;
      logic [15:0] v0, v1, e;
      rd(1'b1, v0);
      restart();
      cfg_width = 2'b11; cfg_bit_rev = 1'b1;
      send_seq(2, 20, 0);
      chk("R11 locked on reversed 20-bit stream", locked, 1);
      send_seq(6, 20, 0);
      send_seq(1, 20, 20'h80001);
      rd(1'b0, e); chk("R11 reversed 20-bit stream exact errors", e, 2);
      rd(1'b1, v1); chk("R2 20-bit samples counted", v1, v0 + 7);
      cfg_bit_rev = 1'b0;
   endtask

   task automatic t_reserved;
      logic [15:0] v0, v1;
      rd(1'b1, v0);
      restart();
      cfg_width = 2'b01;
      send_seq(4, 20, 0);
      rd(1'b1, v1); chk("R2 reserved code counts nothing", v1, v0);
      chk("R2 reserved code stays unlocked", locked, 0);
      cfg_width = 2'b11;
   endtask

   task automatic t_lock_loss;
      logic [15:0] e0, e1;
      restart();
      send_seq(2, 20, 0);
      rd(1'b0, e0);
      send_seq(7, 20, 20'h00010);
      chk("R12 still locked after seven bad words", locked, 1);
      send_seq(1, 20, 0);
      send_seq(7, 20, 20'h00400);
      chk("R12 clean word restarts run count", locked, 1);
      send_seq(1, 20, 20'h00400);
      chk("R12 lock lost after eight bad words", locked, 0);
      rd(1'b0, e1); chk("R12 errors of the bad words", e1, e0 + 15);
      send_seq(2, 20, 0);
      chk("R12 relocked after new seed", locked, 1);
      send_seq(3, 20, 0);
      rd(1'b0, e1); chk("R5 clean after relock", e1, e0 + 15);
   endtask

   task automatic t_saturate;
      logic [15:0] v;
      restart();
      send_seq(6000, 20, 20'hFFFFF);
      rd(1'b0, v); chk("R6 error counter saturates", v, 16'hFFFF);
      restart();
      send_seq(66000, 20, 0);
      rd(1'b1, v); chk("R6 sample counter saturates", v, 16'hFFFF);
      rd(1'b0, v); chk("R6 error counter stays at max", v, 16'hFFFF);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog all act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_user_data();
      t_clean16();
      t_inject();
      t_read_clear();
      t_wide_rev();
      t_reserved();
      t_lock_loss();
      t_saturate();
      summary();
      $finish;
   end
endmodule